// File: doc/BRIEF.md
# Flash Command Sequencer with Toggle-Bit Completion Polling

This block sits on the host side of an asynchronous byte-wide flash bus. It turns a single request into the unlock-and-command write sequence the flash expects: program one byte, erase the whole chip, or erase one sector. It then reads the flash status byte over and over until the operation finishes, and reports the result as a one-cycle done or fail pulse. Every bus access is one cycle of a shared strobe engine. The engine holds the chip enable low for a setup phase, a strobe phase and a hold phase. Each phase lasts a parameterised number of clock cycles.

Completion is decided from bit 6 of two reads in a row. If bit 6 is the same in both reads, the operation has finished. If it changed and bit 5 (the time-limit flag) is set, two more reads settle whether the toggling stopped just as the flag rose. A failure, whether confirmed or caused by running out of polling reads, is followed by a single F0h write that puts the flash back in read mode. Only after that write does the fail pulse appear.

Top module: `flash_cmd_driver`

## Requirements
- R1: Op code 0 (byte program) issues four writes, as data@address: AAh@555h, 55h@2AAh, A0h@555h, then the request data to the request address. Command addresses are the 11-bit values 555h/2AAh, with the upper address bits zero.
- R2: Op code 1 (chip erase) issues six writes: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h.
- R3: Op code 2 (sector erase) issues the same first five writes as R2, and its sixth write is 30h to the request address.
- R4: WE is driven low only while CE is low, OE is high and the data bus is driven. WE and OE are never low together.
- R5: Every write strobe holds WE low for exactly T_PULSE clock cycles.
- R6: After the command writes, status reads come in pairs. If bit 6 is equal in both reads of a pair, done_o pulses and no further write follows.
- R7: If bit 6 differs within a pair and bit 5 of the second read is 0, polling continues with a new pair.
- R8: If bit 6 differs and bit 5 is 1, one confirming pair is read. If bit 6 is equal in that pair, done_o pulses.
- R9: If bit 6 also differs in the confirming pair, one write of F0h to address 0 is issued, and then fail_o pulses.
- R10: When a pair ends with bit 6 still toggling and the total number of status reads has reached MAX_POLLS, the F0h write is issued and fail_o pulses.
- R11: busy_o rises in the cycle after an accepted request and falls in the cycle done_o or fail_o pulses. These two pulses never coincide. A request with op code 3, or a request made while busy_o is high, is ignored.
- R12: After reset, CE, WE and OE are high and busy_o, done_o and fail_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, sampled when idle |
| op_i | input | 2 | 0 program, 1 chip erase, 2 sector erase, 3 none |
| addr_i | input | AW | Target byte or sector address |
| wdata_i | input | 8 | Byte to program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |
| fl_addr_o | output | AW | Flash address bus |
| fl_dq_o | output | 8 | Flash data out |
| fl_dq_oe_o | output | 1 | Data bus drive enable |
| fl_dq_i | input | 8 | Flash data in |
| fl_ce_no | output | 1 | Chip enable, active low |
| fl_we_no | output | 1 | Write enable, active low |
| fl_oe_no | output | 1 | Output enable, active low |

## Verification
The assertions assume that the flash returns a stable status byte for the whole strobe phase of a read. They also assume that reset is the only thing that aborts a bus cycle partway through. The bench's flash model meets both assumptions: it updates its status byte only on the falling edge of OE and then holds it until the next read. The bench drives requests only at falling clock edges, so a request is always sampled cleanly. Its busy-period request and its op-3 request both fall inside windows where the design must ignore them.

// File: rtl/flash_drv_pkg.sv
package flash_drv_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_CHIP = 2'd1,
    OP_SECT = 2'd2,
    OP_NONE = 2'd3
  } op_e;

  localparam logic [10:0] ADDR_UNLK_A = 11'h555;
  localparam logic [10:0] ADDR_UNLK_B = 11'h2AA;
  localparam logic [7:0]  D_UNLK_1    = 8'hAA;
  localparam logic [7:0]  D_UNLK_2    = 8'h55;
  localparam logic [7:0]  D_PROG      = 8'hA0;
  localparam logic [7:0]  D_ERASE     = 8'h80;
  localparam logic [7:0]  D_CHIP      = 8'h10;
  localparam logic [7:0]  D_SECT      = 8'h30;
  localparam logic [7:0]  D_RESET     = 8'hF0;

  localparam int unsigned BIT_TOGGLE = 6;
  localparam int unsigned BIT_LIMIT  = 5;
endpackage

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
  import flash_drv_pkg::*;
#(
  parameter int unsigned AW = 19  // must be >= 11
) (
  input  op_e           op_i,
  input  logic [2:0]    step_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic [AW-1:0] cmd_addr_o,
  output logic [7:0]    cmd_data_o,
  output logic          last_o
);
  localparam logic [AW-1:0] A_UA = AW'(ADDR_UNLK_A);
  localparam logic [AW-1:0] A_UB = AW'(ADDR_UNLK_B);

  always_comb begin
    cmd_addr_o = A_UA;
    cmd_data_o = D_UNLK_1;
    last_o     = 1'b0;
    if (op_i == OP_PROG) begin
      last_o = (step_i == 3'd3);
      case (step_i)
        3'd0:    begin cmd_addr_o = A_UA;   cmd_data_o = D_UNLK_1; end
        3'd1:    begin cmd_addr_o = A_UB;   cmd_data_o = D_UNLK_2; end
        3'd2:    begin cmd_addr_o = A_UA;   cmd_data_o = D_PROG;   end
        default: begin cmd_addr_o = addr_i; cmd_data_o = data_i;   end
      endcase
    end else begin
      last_o = (step_i == 3'd5);
      case (step_i)
        3'd0, 3'd3: begin cmd_addr_o = A_UA; cmd_data_o = D_UNLK_1; end
        3'd1, 3'd4: begin cmd_addr_o = A_UB; cmd_data_o = D_UNLK_2; end
        3'd2:       begin cmd_addr_o = A_UA; cmd_data_o = D_ERASE;  end
        default: begin
          if (op_i == OP_SECT) begin
            cmd_addr_o = addr_i;
            cmd_data_o = D_SECT;
          end else begin
            cmd_addr_o = A_UA;
            cmd_data_o = D_CHIP;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle #(
  parameter int unsigned AW      = 19,
  parameter int unsigned T_SETUP = 1,
  parameter int unsigned T_PULSE = 2,
  parameter int unsigned T_HOLD  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          done_o,
  output logic [7:0]    rdata_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_dq_o,
  output logic          fl_dq_oe_o,
  input  logic [7:0]    fl_dq_i,
  output logic          fl_ce_no,
  output logic          fl_we_no,
  output logic          fl_oe_no
);
  localparam int unsigned TMAX = (T_SETUP > T_PULSE) ?
                                 ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD) :
                                 ((T_PULSE > T_HOLD) ? T_PULSE : T_HOLD);
  localparam int unsigned CW = $clog2(TMAX + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} ph_e;

  ph_e           ph_q;
  logic [CW-1:0] cnt_q;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [7:0]    rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q   <= PH_SETUP;
          cnt_q  <= CW'(T_SETUP - 1);
          wr_q   <= wr_i;
          addr_q <= addr_i;
          data_q <= data_i;
        end
        PH_SETUP: begin
          if (cnt_q == '0) begin
            ph_q  <= PH_STROBE;
            cnt_q <= CW'(T_PULSE - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_STROBE: begin
          if (cnt_q == '0) begin
            ph_q  <= PH_HOLD;
            cnt_q <= CW'(T_HOLD - 1);
            if (!wr_q) rdata_q <= fl_dq_i;  // sample at end of read strobe
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: begin
          if (cnt_q == '0) ph_q <= PH_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
      endcase
    end
  end

  assign done_o     = (ph_q == PH_HOLD) && (cnt_q == '0);
  assign rdata_o    = rdata_q;
  assign fl_addr_o  = addr_q;
  assign fl_dq_o    = data_q;
  assign fl_dq_oe_o = wr_q && (ph_q != PH_IDLE);
  assign fl_ce_no   = (ph_q == PH_IDLE);
  assign fl_we_no   = !((ph_q == PH_STROBE) && wr_q);
  assign fl_oe_no   = !((ph_q == PH_STROBE) && !wr_q);
endmodule

// File: rtl/flash_cmd_driver.sv
module flash_cmd_driver
  import flash_drv_pkg::*;
#(
  parameter int unsigned AW        = 19,
  parameter int unsigned T_SETUP   = 1,
  parameter int unsigned T_PULSE   = 2,
  parameter int unsigned T_HOLD    = 1,
  parameter int unsigned MAX_POLLS = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_dq_o,
  output logic          fl_dq_oe_o,
  input  logic [7:0]    fl_dq_i,
  output logic          fl_ce_no,
  output logic          fl_we_no,
  output logic          fl_oe_no
);
  localparam int unsigned RCW = $clog2(MAX_POLLS + 3);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_POLL, S_CONF, S_RST} st_e;

  st_e            st_q;
  op_e            op_q;
  logic [AW-1:0]  addr_q;
  logic [7:0]     data_q;
  logic [2:0]     step_q;
  logic           pend_q;
  logic           half_q;
  logic [7:0]     first_q;
  logic [RCW-1:0] rd_cnt_q;
  logic           done_q, fail_q;

  logic [AW-1:0]  rom_addr;
  logic [7:0]     rom_data;
  logic           rom_last;
  logic           cyc_start, cyc_wr, cyc_done;
  logic [AW-1:0]  cyc_addr;
  logic [7:0]     cyc_data, cyc_rdata;
  logic [RCW-1:0] rd_next;
  logic           toggled;

  flash_cmd_rom #(.AW(AW)) u_rom (
    .op_i      (op_q),
    .step_i    (step_q),
    .addr_i    (addr_q),
    .data_i    (data_q),
    .cmd_addr_o(rom_addr),
    .cmd_data_o(rom_data),
    .last_o    (rom_last)
  );

  always_comb begin
    cyc_start = (st_q != S_IDLE) && !pend_q;
    cyc_wr    = (st_q == S_CMD) || (st_q == S_RST);
    cyc_addr  = addr_q;
    cyc_data  = D_RESET;
    if (st_q == S_CMD) begin
      cyc_addr = rom_addr;
      cyc_data = rom_data;
    end else if (st_q == S_RST) begin
      cyc_addr = '0;
    end
  end

  flash_bus_cycle #(
    .AW(AW), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD)
  ) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (cyc_start),
    .wr_i      (cyc_wr),
    .addr_i    (cyc_addr),
    .data_i    (cyc_data),
    .done_o    (cyc_done),
    .rdata_o   (cyc_rdata),
    .fl_addr_o (fl_addr_o),
    .fl_dq_o   (fl_dq_o),
    .fl_dq_oe_o(fl_dq_oe_o),
    .fl_dq_i   (fl_dq_i),
    .fl_ce_no  (fl_ce_no),
    .fl_we_no  (fl_we_no),
    .fl_oe_no  (fl_oe_no)
  );

  assign rd_next = rd_cnt_q + 1'b1;
  assign toggled = first_q[BIT_TOGGLE] ^ cyc_rdata[BIT_TOGGLE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      op_q     <= OP_NONE;
      addr_q   <= '0;
      data_q   <= '0;
      step_q   <= '0;
      pend_q   <= 1'b0;
      half_q   <= 1'b0;
      first_q  <= '0;
      rd_cnt_q <= '0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      if (cyc_start) pend_q <= 1'b1;
      else if (cyc_done) pend_q <= 1'b0;
      case (st_q)
        S_IDLE: if (req_i && (op_e'(op_i) != OP_NONE)) begin
          st_q   <= S_CMD;
          op_q   <= op_e'(op_i);
          addr_q <= addr_i;
          data_q <= wdata_i;
          step_q <= '0;
        end
        S_CMD: if (cyc_done) begin
          if (rom_last) begin
            st_q     <= S_POLL;
            half_q   <= 1'b0;
            rd_cnt_q <= '0;
          end else step_q <= step_q + 1'b1;
        end
        S_POLL, S_CONF: if (cyc_done) begin
          rd_cnt_q <= rd_next;
          if (!half_q) begin
            first_q <= cyc_rdata;
            half_q  <= 1'b1;
          end else begin
            half_q <= 1'b0;
            if (!toggled) begin
              st_q   <= S_IDLE;
              done_q <= 1'b1;
            end else if (st_q == S_CONF) begin
              st_q <= S_RST;
            end else if (cyc_rdata[BIT_LIMIT]) begin
              st_q <= S_CONF;
            end else if (rd_next >= RCW'(MAX_POLLS)) begin
              st_q <= S_RST;  // polling budget spent
            end
          end
        end
        default: if (cyc_done) begin
          st_q   <= S_IDLE;
          fail_q <= 1'b1;
        end
      endcase
    end
  end

  assign busy_o = (st_q != S_IDLE);
  assign done_o = done_q;
  assign fail_o = fail_q;
endmodule

// File: rtl/flash_cmd_driver_chk.sv
module flash_cmd_driver_chk #(
  parameter int unsigned T_PULSE = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       done_o,
  input logic       fail_o,
  input logic [7:0] fl_dq_o,
  input logic       fl_dq_oe_o,
  input logic       fl_ce_no,
  input logic       fl_we_no,
  input logic       fl_oe_no
);
  logic [7:0] we_lo_cnt;
  logic [7:0] last_wd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_cnt <= '0;
      last_wd   <= '0;
    end else begin
      if (!fl_we_no) begin
        we_lo_cnt <= we_lo_cnt + 1'b1;
        last_wd   <= fl_dq_o;
      end else begin
        we_lo_cnt <= '0;
      end
    end
  end

  assert_we_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_we_no |-> (!fl_ce_no && fl_oe_no && fl_dq_oe_o));

  assert_we_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_we_no) |-> (we_lo_cnt == 8'(T_PULSE)));

  assert_fail_after_reset_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (last_wd == 8'hF0));

  assert_one_result_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  assert_busy_drop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fail_o) |-> !busy_o);

  assert_bus_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (fl_ce_no && fl_we_no && fl_oe_no));
endmodule

bind flash_cmd_driver flash_cmd_driver_chk #(.T_PULSE(T_PULSE)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .fail_o    (fail_o),
  .fl_dq_o   (fl_dq_o),
  .fl_dq_oe_o(fl_dq_oe_o),
  .fl_ce_no  (fl_ce_no),
  .fl_we_no  (fl_we_no),
  .fl_oe_no  (fl_oe_no)
);

// File: tb/sim_flash_cmd_driver.sv
module sim_flash_cmd_driver;
  localparam int AW = 19;
  localparam int TS = 1;
  localparam int TP = 2;
  localparam int TH = 1;
  localparam int MP = 16;

  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic [7:0]    data;
    logic [10:0]   busy;   // toggling reads, 1000 = never stops
    logic          q5;
    logic          fail;
    logic [7:0]    reads;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 19'h12345, 8'h5A, 11'd0,    1'b0, 1'b0, 8'd2},
    '{2'd0, 19'h7FFFF, 8'hFF, 11'd5,    1'b0, 1'b0, 8'd6},
    '{2'd1, 19'h00000, 8'h00, 11'd4,    1'b0, 1'b0, 8'd6},
    '{2'd2, 19'h30000, 8'h00, 11'd1,    1'b0, 1'b0, 8'd2},
    '{2'd0, 19'h00ABC, 8'h3C, 11'd3,    1'b1, 1'b0, 8'd4},
    '{2'd2, 19'h50000, 8'h00, 11'd1000, 1'b1, 1'b1, 8'd4},
    '{2'd1, 19'h00000, 8'h00, 11'd1000, 1'b0, 1'b1, 8'd16},
    '{2'd0, 19'h00001, 8'h81, 11'd2,    1'b1, 1'b0, 8'd4}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req;
  logic [1:0]    op;
  logic [AW-1:0] addr;
  logic [7:0]    wdata;
  logic          busy, done, fail;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dq_o, fl_dq_i;
  logic          fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  flash_cmd_driver #(
    .AW(AW), .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH), .MAX_POLLS(MP)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .fail_o(fail),
    .fl_addr_o(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe_o(fl_dq_oe),
    .fl_dq_i(fl_dq_i), .fl_ce_no(fl_ce_n), .fl_we_no(fl_we_n), .fl_oe_no(fl_oe_n)
  );

  // flash model
  logic          log_en = 1'b0;
  int            wcount = 0;
  int            rcount = 0;
  logic [AW-1:0] wa [16];
  logic [7:0]    wd [16];
  int            busy_left = 0;
  logic          t6 = 1'b0;
  logic          q5m = 1'b0;
  int            we_lo = 0;
  int            we_width = 0;
  int            bad_strobe = 0;

  assign fl_dq_i = {1'b0, t6, q5m, 5'b0};

  always @(posedge clk) begin
    if (log_en && !fl_we_n) we_lo++;
    if (log_en && !fl_we_n && !fl_oe_n) bad_strobe++;
  end

  always @(posedge fl_we_n) begin
    if (log_en && !fl_ce_n) begin
      if (wcount < 16) begin
        wa[wcount] = fl_addr;
        wd[wcount] = fl_dq_o;
      end
      wcount++;
      we_width = we_lo;
    end
    we_lo = 0;
  end

  always @(negedge fl_oe_n) begin
    if (log_en && !fl_ce_n) begin
      rcount++;
      if (busy_left > 0) begin
        t6 = ~t6;
        busy_left--;
      end
    end
  end

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  function automatic int seq_len(input logic [1:0] o);
    return (o == 2'd0) ? 4 : 6;
  endfunction

  task automatic exp_word(input logic [1:0] o, input int idx, input logic [AW-1:0] a,
                          input logic [7:0] d, output logic [AW-1:0] ea, output logic [7:0] ed);
    ea = 19'h555;
    ed = 8'hAA;
    if (idx >= seq_len(o)) begin ea = '0; ed = 8'hF0; end
    else if (o == 2'd0) begin
      case (idx)
        0: begin ea = 19'h555; ed = 8'hAA; end
        1: begin ea = 19'h2AA; ed = 8'h55; end
        2: begin ea = 19'h555; ed = 8'hA0; end
        default: begin ea = a; ed = d; end
      endcase
    end else begin
      case (idx)
        0, 3: begin ea = 19'h555; ed = 8'hAA; end
        1, 4: begin ea = 19'h2AA; ed = 8'h55; end
        2: begin ea = 19'h555; ed = 8'h80; end
        default: begin
          if (o == 2'd2) begin ea = a; ed = 8'h30; end
          else begin ea = 19'h555; ed = 8'h10; end
        end
      endcase
    end
  endtask

  task automatic prep_model(input int b, input logic q5);
    busy_left = b;
    q5m = q5;
    t6 = 1'b0;
    wcount = 0;
    rcount = 0;
  endtask

  task automatic wait_result(output bit got_done, output bit got_fail);
    got_done = 0;
    got_fail = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done || fail) begin
        got_done = done;
        got_fail = fail;
        break;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R11 watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    bit gd, gf;
    logic [AW-1:0] ea;
    logic [7:0] ed;
    string seq_tag, res_tag;

    rst_n = 1'b0;
    req = 1'b0;
    op = 2'd0;
    addr = '0;
    wdata = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check(fl_ce_n && fl_we_n && fl_oe_n, "R12 strobes", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    check(!busy && !done && !fail, "R12 status", {busy, done, fail}, 0);
    rst_n = 1'b1;
    log_en = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      prep_model(int'(VECS[v].busy), VECS[v].q5);
      op = VECS[v].op;
      addr = VECS[v].addr;
      wdata = VECS[v].data;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      check(busy == 1'b1, "R11 busy after accept", busy, 1);
      wait_result(gd, gf);
      seq_tag = (VECS[v].op == 2'd0) ? "R1" : (VECS[v].op == 2'd1) ? "R2" : "R3";
      if (VECS[v].fail && VECS[v].reads == 8'(MP)) res_tag = "R10";
      else if (VECS[v].fail) res_tag = "R9";
      else if (VECS[v].q5) res_tag = "R8";
      else if (VECS[v].busy > 1) res_tag = "R7";
      else res_tag = "R6";
      check(gd == !VECS[v].fail, {res_tag, " done"}, gd, !VECS[v].fail);
      check(gf == VECS[v].fail, {res_tag, " fail"}, gf, VECS[v].fail);
      check(rcount == int'(VECS[v].reads), {res_tag, " reads"}, rcount, VECS[v].reads);
      check(wcount == seq_len(VECS[v].op) + int'(VECS[v].fail), {seq_tag, " write count"},
            wcount, seq_len(VECS[v].op) + int'(VECS[v].fail));
      for (int k = 0; k < wcount && k < 16; k++) begin
        exp_word(VECS[v].op, k, VECS[v].addr, VECS[v].data, ea, ed);
        check(wa[k] == ea, (k >= seq_len(VECS[v].op)) ? "R9 reset addr" : {seq_tag, " addr"},
              int'(wa[k]), int'(ea));
        check(wd[k] == ed, (k >= seq_len(VECS[v].op)) ? "R9 reset data" : {seq_tag, " data"},
              int'(wd[k]), int'(ed));
      end
      check(we_width == TP, "R5 strobe width", we_width, TP);
      @(negedge clk);
      check(!busy, "R11 busy cleared", busy, 0);
    end

    // R11: op code 3 ignored
    prep_model(0, 1'b0);
    op = 2'd3;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check(!busy, "R11 op3 busy", busy, 0);
    repeat (20) @(negedge clk);
    check(wcount == 0 && rcount == 0, "R11 op3 bus idle", wcount + rcount, 0);

    // R11: request during busy ignored
    prep_model(6, 1'b0);
    op = 2'd0;
    addr = 19'h00100;
    wdata = 8'h11;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    op = 2'd1;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait_result(gd, gf);
    check(gd, "R11 first op done", gd, 1);
    repeat (30) @(negedge clk);
    check(!busy, "R11 no second op", busy, 0);
    check(wcount == 4, "R11 busy request dropped", wcount, 4);
    check(rcount == 8, "R7 reads with busy 6", rcount, 8);

    // R4: write and read strobes never overlap
    check(bad_strobe == 0, "R4 strobe overlap", bad_strobe, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule